// File: doc/BRIEF.md
# I2C Serial Memory Target

This block is a synchronous I2C target in front of a small byte-wide memory. The system clock oversamples SCL and SDA after a two-flop synchronizer. The block finds START and STOP conditions on the bus and answers one 7-bit device address. That address is built from a fixed five-bit prefix and two strap pins, so up to four copies can sit on one bus. It acknowledges received bytes and runs write or streaming-read transfers. SDA is modelled as an open-drain enable: the block either pulls the line low or leaves it released.

After a write address, the first two data bytes set an internal word pointer, high byte first. Each later byte is stored at the pointer, and the pointer then steps by one. A read returns bytes from the pointer, one after another, for as long as the master keeps acknowledging. The pointer wraps around at the top of the array.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset, and at any time the block is idle, no bus activity other than a START (SDA falling while SCL is high) gets a response. In particular, no byte is acknowledged.
- R2: A STOP (SDA rising while SCL is high) ends any transfer, releases SDA and returns the block to idle.
- R3: The first byte after a START is the device address, sent MSB first. Bits 7..3 must be 10100, bits 2..1 must equal `straps_i[1:0]`, and bit 0 set to 1 selects read. On a match the block acknowledges by holding SDA low through the ninth SCL pulse. On a mismatch it leaves SDA released for the rest of the transfer.
- R4: In write mode, every 8-bit byte received is acknowledged on its ninth clock.
- R5: The first two bytes after a write address load the pointer (high byte first, truncated to the array's address width). Each later byte is written at the pointer, and the pointer then increments.
- R6: In read mode the block sends the byte at the pointer, MSB first, then increments the pointer. It releases SDA for the ninth clock and samples the master's acknowledge on that clock's rising edge.
- R7: An acknowledge from the master (SDA low) makes the block send the next byte. No acknowledge makes it stop driving and go idle until the next START.
- R8: The pointer wraps from the highest array address to address zero, for both writes and reads.
- R9: An SDA change while SCL is high in the middle of a byte is taken as a START or a STOP and never as data. The partly received byte is discarded and is not written.
- R10: The SDA drive output changes only while SCL is low, apart from the release that follows a START or a STOP.
- R11: While reset is asserted, and right after it, SDA is released and the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND value) |
| straps_i | input | 2 | Device address bits 2..1 |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench targets bytes clocked in with no START before them, and a START or a STOP placed partway through a byte. A design that treated those SCL edges as data would acknowledge them or store a partly received byte. Pointer accesses are run across the top of the array, where a design without wrap would read back the wrong bytes after address 255. Address bytes are sent with a wrong prefix and with wrong strap bits, and a design that decoded these loosely would acknowledge them or write memory. After a master NACK the bench clocks another byte, and a design that kept driving would show up as zero bits on the line.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  localparam logic [4:0] DEV_PREFIX = 5'b10100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_PREP,
    ST_ACK,
    ST_WR,
    ST_RD,
    ST_RD_ACK,
    ST_RD_NEXT
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_PTR_HI,
    PH_PTR_LO,
    PH_DATA
  } wr_phase_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_s, sda_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s      = scl_pipe[STAGES-1];
  assign sda_s      = sda_pipe[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_mem_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [1:0]    straps,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          idle
);

  localparam logic [AW-1:0] PTR_ONE = AW'(1);

  tgt_state_e    state_q, state_d;
  wr_phase_e     phase_q, phase_d;
  logic [3:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic [7:0]    hi_q, hi_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          rw_q, rw_d;
  logic          oe_q, oe_d;
  logic [7:0]    rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_PTR_HI;
      bit_q   <= '0;
      sh_q    <= '0;
      hi_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      hi_q    <= hi_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      oe_q    <= oe_d;
    end
  end

  assign rx_byte = {sh_q[6:0], sda_s};

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    hi_d    = hi_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    mem_we  = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = rx_byte;
            bit_d = bit_q + 4'd1;
            if (bit_q == 4'd7) begin
              if (rx_byte[7:3] == DEV_PREFIX && rx_byte[2:1] == straps) begin
                rw_d    = rx_byte[0];
                phase_d = PH_PTR_HI;
                state_d = ST_ACK_PREP;
              end else begin
                state_d = ST_IDLE;
              end
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            sh_d  = rx_byte;
            bit_d = bit_q + 4'd1;
            if (bit_q == 4'd7) begin
              state_d = ST_ACK_PREP;
              case (phase_q)
                PH_PTR_HI: begin
                  hi_d    = rx_byte;
                  phase_d = PH_PTR_LO;
                end
                PH_PTR_LO: begin
                  ptr_d   = AW'({hi_q, rx_byte});
                  phase_d = PH_DATA;
                end
                default: begin
                  mem_we = 1'b1;
                  ptr_d  = ptr_q + PTR_ONE;
                end
              endcase
            end
          end
        end
        ST_ACK_PREP: begin
          if (scl_fall) begin
            oe_d    = 1'b1;
            state_d = ST_ACK;
          end
        end
        ST_ACK, ST_RD_NEXT: begin
          if (scl_fall) begin
            if (rw_q) begin
              oe_d    = ~rd_data[7];
              sh_d    = {rd_data[6:0], 1'b0};
              bit_d   = 4'd1;
              ptr_d   = ptr_q + PTR_ONE;
              state_d = ST_RD;
            end else begin
              oe_d    = 1'b0;
              bit_d   = '0;
              state_d = ST_WR;
            end
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d    = 1'b0;
              state_d = ST_RD_ACK;
            end else begin
              oe_d  = ~sh_q[7];
              sh_d  = {sh_q[6:0], 1'b0};
              bit_d = bit_q + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            state_d = sda_s ? ST_IDLE : ST_RD_NEXT;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign sda_oe    = oe_q;
  assign mem_addr  = ptr_q;
  assign mem_wdata = rx_byte;
  assign idle      = (state_q == ST_IDLE);

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int MEM_AW      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] straps_i,
  output logic       sda_drive_low_o
);

  logic              sda_s, scl_rise, scl_fall;
  logic              start_det, stop_det, ctrl_idle;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_target_ctrl #(.AW(MEM_AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .straps    (straps_i),
    .rd_data   (mem_rdata),
    .sda_oe    (sda_drive_low_o),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .idle      (ctrl_idle)
  );

  i2c_mem_array #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_drive_low_o,
  input logic start_det,
  input logic stop_det,
  input logic idle
);

  // R10
  drive_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_drive_low_o != $past(sda_drive_low_o)) && !$past(start_det) && !$past(stop_det))
      |-> !scl_i);

  // R2
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (idle && !sda_drive_low_o));

  // R1
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start_det) |=> idle);

  // R1
  start_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> !idle);

  // R11
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_drive_low_o);

endmodule

bind i2c_mem_target i2c_mem_target_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .scl_i           (scl_i),
  .sda_drive_low_o (sda_drive_low_o),
  .start_det       (start_det),
  .stop_det        (stop_det),
  .idle            (ctrl_idle)
);

// File: tb/tb_i2c_mem_target.sv
module tb_i2c_mem_target;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;

  logic       clk;
  logic       rst_n;
  logic       scl;
  logic       m_low;
  logic [1:0] straps;
  logic       sda_drive_low_o;
  logic       sda_line;

  int checks;
  int failures;
  bit done;

  logic [7:0] exp_q[$];
  logic [7:0] obs_q[$];
  string      req_q[$];

  assign sda_line = ~(m_low | sda_drive_low_o);

  i2c_mem_target dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (scl),
    .sda_i           (sda_line),
    .straps_i        (straps),
    .sda_drive_low_o (sda_drive_low_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wbit(input logic b);
    m_low = ~b;
    half(); scl = 1'b1; half(); half(); scl = 1'b0; half();
  endtask

  task automatic rbit(output logic b);
    m_low = 1'b0;
    half(); scl = 1'b1; half(); b = sda_line; half(); scl = 1'b0; half();
  endtask

  task automatic start_c();
    m_low = 1'b0; half(); scl = 1'b1; half(); m_low = 1'b1; half(); scl = 1'b0; half();
  endtask

  task automatic stop_c();
    m_low = 1'b1; half(); scl = 1'b1; half(); m_low = 1'b0; half();
  endtask

  task automatic send(input logic [7:0] d, input logic exp_ack, input string req);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    chk((~b) == exp_ack, req, int'(~b), int'(exp_ack));
  endtask

  // driver: pushes the expected byte, then clocks the byte in from the line
  task automatic recv(input logic [7:0] exp, input logic mack, input string req);
    logic [7:0] d;
    logic       b;
    exp_q.push_back(exp);
    req_q.push_back(req);
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(~mack);
    m_low = 1'b0;
    obs_q.push_back(d);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      logic [7:0] o, e;
      string      r;
      wait (obs_q.size() != 0);
      o = obs_q.pop_front();
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(o == e, r, o, e);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    scl = 1'b1; m_low = 1'b0; straps = 2'b10; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(sda_drive_low_o == 1'b0, "R11 in reset", sda_drive_low_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_drive_low_o == 1'b0, "R11 after reset", sda_drive_low_o, 0);

    // R1: bytes without any START
    scl = 1'b0; half();
    send(8'hA4, 1'b0, "R1 no start addr");
    send(8'h00, 1'b0, "R1 no start data");

    // R3/R4/R5: write 11 22 33 at 0x010
    start_c();
    send(8'hA4, 1'b1, "R3 write addr match");
    send(8'h00, 1'b1, "R5 ptr hi");
    send(8'h10, 1'b1, "R5 ptr lo");
    send(8'h11, 1'b1, "R4 data0");
    send(8'h22, 1'b1, "R4 data1");
    send(8'h33, 1'b1, "R4 data2");
    stop_c();

    // R6/R7: read back with repeated START
    start_c();
    send(8'hA4, 1'b1, "R3 addr");
    send(8'h00, 1'b1, "R5 ptr hi");
    send(8'h10, 1'b1, "R5 ptr lo");
    start_c();
    send(8'hA5, 1'b1, "R3 read addr match");
    recv(8'h11, 1'b1, "R6 byte0");
    recv(8'h22, 1'b1, "R6 R7 byte1");
    recv(8'h33, 1'b0, "R6 byte2");
    recv(8'hFF, 1'b0, "R7 released after nack");
    stop_c();

    // R3: wrong strap bits and wrong prefix
    start_c();
    send(8'hA2, 1'b0, "R3 strap mismatch");
    send(8'h00, 1'b0, "R3 no ack after mismatch");
    send(8'h10, 1'b0, "R3 no ack after mismatch");
    send(8'h99, 1'b0, "R3 no ack after mismatch");
    stop_c();
    start_c();
    send(8'hE4, 1'b0, "R3 prefix mismatch");
    stop_c();

    // R8: write across the top, read across the top
    start_c();
    send(8'hA4, 1'b1, "R8 addr");
    send(8'h00, 1'b1, "R8 ptr hi");
    send(8'hFE, 1'b1, "R8 ptr lo");
    send(8'hAA, 1'b1, "R8 data FE");
    send(8'hBB, 1'b1, "R8 data FF");
    send(8'hCC, 1'b1, "R8 data 00 wrapped");
    stop_c();
    start_c();
    send(8'hA4, 1'b1, "R8 addr");
    send(8'h00, 1'b1, "R8 ptr hi");
    send(8'hFE, 1'b1, "R8 ptr lo");
    start_c();
    send(8'hA5, 1'b1, "R8 read addr");
    recv(8'hAA, 1'b1, "R8 read FE");
    recv(8'hBB, 1'b1, "R8 read FF");
    recv(8'hCC, 1'b0, "R8 read wrap 00");
    stop_c();

    // R9: START partway through a data byte discards it
    start_c();
    send(8'hA4, 1'b1, "R9 addr");
    send(8'h00, 1'b1, "R9 ptr hi");
    send(8'h10, 1'b1, "R9 ptr lo");
    wbit(1'b0); wbit(1'b1); wbit(1'b0); wbit(1'b1);
    start_c();
    send(8'hA4, 1'b1, "R9 restart recognized");
    send(8'h00, 1'b1, "R9 ptr hi");
    send(8'h10, 1'b1, "R9 ptr lo");
    start_c();
    send(8'hA5, 1'b1, "R9 read addr");
    recv(8'h11, 1'b0, "R9 R3 partial byte not stored");
    stop_c();

    // R2/R9: STOP partway through a byte, then no response without START
    start_c();
    send(8'hA4, 1'b1, "R2 addr");
    wbit(1'b1); wbit(1'b0);
    stop_c();
    scl = 1'b0; half();
    send(8'hA4, 1'b0, "R2 idle after stop");
    stop_c();

    // R3: new strap value
    straps = 2'b01;
    start_c();
    send(8'hA4, 1'b0, "R3 old address ignored");
    stop_c();
    start_c();
    send(8'hA2, 1'b1, "R3 new strap addr");
    send(8'h00, 1'b1, "R5 ptr hi");
    send(8'h11, 1'b1, "R5 ptr lo");
    start_c();
    send(8'hA3, 1'b1, "R3 new strap read");
    recv(8'h22, 1'b0, "R6 read 011");
    stop_c();

    wait (obs_q.size() == 0);
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule